// File: doc/BRIEF.md
# GPIO Bank with Interrupt Sensing

This block is a bank of general-purpose pins, 32 by default, under a small memory-mapped register interface. Each pin is configured on its own as one of three things: a general input, a general output that drives the pad through an output-enable bit, or an interrupt source. An interrupt source is sensed on its level or on its edges. A polarity bit picks high/rising or low/falling for that source, and a both-edge bit makes an edge-sensed pin fire on either transition.

Every pad passes through a two-stage synchronizer. A per-pin input enable then qualifies the synchronized value before anything reads it. Edge events set a sticky status bit, which software clears by writing 1 to the clear register. Level events make the status bit track the active level. A pin reaches the single interrupt output only when its mask bit is 1. Software sets mask bits by writing 1 to the unmask register. It drops them by writing 0 to the mask register, and bits written with 1 there are left as they are. Reads on the bus are combinational, so the data appears in the same cycle as the request.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every configuration register, the mask and the status read 0, so pad_oe is 0 and irq is low.
- R2: pad_oe for a pin is 1 exactly when its direction bit is 1 and its interrupt-select bit is 0. pad_out always equals the output-data register.
- R3: The pin-level register returns each pad value after two clock edges, including pins that are driving outputs. After only one edge it still shows the old value.
- R4: An edge-sensed interrupt pin sets its status on a rising edge when its polarity bit is 0, and on a falling edge when its polarity bit is 1. The status bit stays set until it is cleared.
- R5: An edge-sensed pin whose both-edge bit is 1 sets its status on either transition, whatever its polarity bit.
- R6: For a level-sensed pin (edge-mode bit 0), status equals the qualified pad level, inverted when the polarity bit is 1. A clear write does not drop it while the level is still active.
- R7: Writing 1 to a bit of the clear register drops that pin's edge status, and bits written with 0 are untouched. If a new edge arrives in the same cycle as the clear, the edge wins and the status stays 1.
- R8: A 0 written to a bit of the mask register masks that pin, and a 1 keeps the bit as it was. A 1 written to the unmask register enables the pin. The mask register reads 1 for enabled pins.
- R9: irq is 1 exactly when some pin has both status and mask bits set.
- R10: A pin whose input-enable bit is 0 reads 0 in the pin-level register and never sets status.
- R11: A pin whose interrupt-select bit is 0 always reads 0 in the status register.
- R12: Register offsets are as follows. 0x00 interrupt select (1 means interrupt pin). 0x04 direction (1 means output). 0x08 output data. 0x0C pin level (read only). 0x10 status (read only). 0x14 clear (write only). 0x18 mask. 0x1C unmask (write only). 0x20 polarity. 0x24 edge mode. 0x4C both-edge. 0x50 input enable. Write-only offsets and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid_i | input | 1 | Bus request this cycle |
| bus_write_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | LINES | Write data |
| bus_rdata_o | output | LINES | Read data, same cycle as the request |
| pad_in_i | input | LINES | Raw pad levels, asynchronous |
| pad_out_o | output | LINES | Output data to pads |
| pad_oe_o | output | LINES | Per-pad output enable |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The two functions that can collide are a software clear of a pin's edge status and a new qualifying edge on that same pin. The bench provokes this by counting the two synchronizer edges after a pad change and placing the clear write in the exact cycle where the edge is detected. It then expects the status to read 1, and expects a later clear to drop it. A random phase changes pads, configuration, masks and clears and compares status, pin level and irq with a step-level model.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int ADDR_W = 8;

    typedef enum logic [ADDR_W-1:0] {
        REG_MODE_SEL = 8'h00,
        REG_DIR      = 8'h04,
        REG_OUT      = 8'h08,
        REG_LEVEL    = 8'h0C,
        REG_STATUS   = 8'h10,
        REG_CLEAR    = 8'h14,
        REG_MASK     = 8'h18,
        REG_UNMASK   = 8'h1C,
        REG_POL      = 8'h20,
        REG_EDGE     = 8'h24,
        REG_BOTH     = 8'h4C,
        REG_INEN     = 8'h50
    } reg_addr_e;

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pad_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef logic [WIDTH-1:0] vec_t;

    vec_t chain_d [STAGES];
    vec_t chain_q [STAGES];

    always_comb begin
        chain_d[0] = pad_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                chain_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                chain_q[i] <= chain_d[i];
            end
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    input  logic [WIDTH-1:0] en_i,
    input  logic [WIDTH-1:0] irq_sel_i,
    input  logic [WIDTH-1:0] edge_mode_i,
    input  logic [WIDTH-1:0] pol_i,
    input  logic [WIDTH-1:0] both_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] status_o
);

    typedef logic [WIDTH-1:0] vec_t;

    typedef struct packed {
        vec_t prev;
        vec_t status;
    } sense_t;

    sense_t st_d, st_q;
    vec_t   rise, fall, edge_hit, active, live;

    always_comb begin
        rise     = level_i & ~st_q.prev;
        fall     = ~level_i & st_q.prev;
        edge_hit = (rise & (~pol_i | both_i)) | (fall & (pol_i | both_i));
        active   = level_i ^ pol_i;
        live     = irq_sel_i & en_i;

        st_d.prev   = level_i;
        st_d.status = live & ((edge_mode_i & ((st_q.status & ~clr_i) | edge_hit))
                            | (~edge_mode_i & active));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.status;

    // R7: a latched edge status survives unless cleared or reconfigured
    assert_edge_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(st_q.status & edge_mode_i & irq_sel_i & en_i & ~clr_i)
                   & ~st_q.status) == '0));

    // R7: a clear with no competing edge drops the bit
    assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.status & $past(clr_i & edge_mode_i & ~edge_hit)) == '0));

    // R10 / R11: disabled or non-interrupt pins never hold status
    assert_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.status & ~$past(irq_sel_i & en_i)) == '0));

    // R6: level-sensed status follows the active level one cycle later
    assert_level_track_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((st_q.status ^ $past(level_i ^ pol_i))
                   & $past(~edge_mode_i & irq_sel_i & en_i)) == '0));

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int LINES       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid_i,
    input  logic              bus_write_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [LINES-1:0]  bus_wdata_i,
    output logic [LINES-1:0]  bus_rdata_o,
    input  logic [LINES-1:0]  pad_in_i,
    output logic [LINES-1:0]  pad_out_o,
    output logic [LINES-1:0]  pad_oe_o,
    output logic              irq_o
);

    localparam int WARM_W = $clog2(SYNC_STAGES + 1);

    typedef logic [LINES-1:0] lvec_t;

    typedef struct packed {
        lvec_t             irq_sel;
        lvec_t             dir_out;
        lvec_t             out_val;
        lvec_t             pol;
        lvec_t             edge_md;
        lvec_t             both;
        lvec_t             in_en;
        lvec_t             mask;
        logic [WARM_W-1:0] warm;
    } bank_t;

    bank_t cfg_d, cfg_q;
    logic  wr_en, rd_en;
    lvec_t clr_vec, sync_w, level_w, status_w;

    assign wr_en   = bus_valid_i & bus_write_i;
    assign rd_en   = bus_valid_i & ~bus_write_i;
    assign clr_vec = (wr_en && bus_addr_i == REG_CLEAR) ? bus_wdata_i : '0;

    gpio_pad_sync #(
        .WIDTH  (LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_i  (pad_in_i),
        .sync_o (sync_w)
    );

    assign level_w = sync_w & cfg_q.in_en;

    gpio_irq_sense #(
        .WIDTH (LINES)
    ) u_sense (
        .clk         (clk),
        .rst_n       (rst_n),
        .level_i     (level_w),
        .en_i        (cfg_q.in_en),
        .irq_sel_i   (cfg_q.irq_sel),
        .edge_mode_i (cfg_q.edge_md),
        .pol_i       (cfg_q.pol),
        .both_i      (cfg_q.both),
        .clr_i       (clr_vec),
        .status_o    (status_w)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_q.warm != WARM_W'(SYNC_STAGES)) begin
            cfg_d.warm = cfg_q.warm + 1'b1;
        end
        if (wr_en) begin
            case (bus_addr_i)
                REG_MODE_SEL: cfg_d.irq_sel = bus_wdata_i;
                REG_DIR:      cfg_d.dir_out = bus_wdata_i;
                REG_OUT:      cfg_d.out_val = bus_wdata_i;
                REG_POL:      cfg_d.pol     = bus_wdata_i;
                REG_EDGE:     cfg_d.edge_md = bus_wdata_i;
                REG_BOTH:     cfg_d.both    = bus_wdata_i;
                REG_INEN:     cfg_d.in_en   = bus_wdata_i;
                REG_MASK:     cfg_d.mask    = cfg_q.mask & bus_wdata_i;
                REG_UNMASK:   cfg_d.mask    = cfg_q.mask | bus_wdata_i;
                default:      ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        if (rd_en) begin
            case (bus_addr_i)
                REG_MODE_SEL: bus_rdata_o = cfg_q.irq_sel;
                REG_DIR:      bus_rdata_o = cfg_q.dir_out;
                REG_OUT:      bus_rdata_o = cfg_q.out_val;
                REG_LEVEL:    bus_rdata_o = level_w;
                REG_STATUS:   bus_rdata_o = status_w;
                REG_MASK:     bus_rdata_o = cfg_q.mask;
                REG_POL:      bus_rdata_o = cfg_q.pol;
                REG_EDGE:     bus_rdata_o = cfg_q.edge_md;
                REG_BOTH:     bus_rdata_o = cfg_q.both;
                REG_INEN:     bus_rdata_o = cfg_q.in_en;
                default:      bus_rdata_o = '0;
            endcase
        end
    end

    assign pad_out_o = cfg_q.out_val;
    assign pad_oe_o  = cfg_q.dir_out & ~cfg_q.irq_sel;
    assign irq_o     = |(status_w & cfg_q.mask);

    // R8: a write to the mask offset never enables a pin
    assert_mask_only_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr_i == REG_MASK) |=> ((cfg_q.mask & ~$past(cfg_q.mask)) == '0));

    // R8: a write to the unmask offset never disables a pin
    assert_unmask_only_adds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr_i == REG_UNMASK) |=> (($past(cfg_q.mask) & ~cfg_q.mask) == '0));

    generate
        if (SYNC_STAGES == 2) begin : g_lat_chk
            // R3: the pin level is the pad value from two edges earlier, qualified
            assert_level_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_q.warm == WARM_W'(SYNC_STAGES))
                |-> (level_w == ($past(pad_in_i, 2) & cfg_q.in_en)));
        end
    endgenerate

endmodule

// File: tb/gpio_irq_bank_bench.sv
`timescale 1ns/1ps
module gpio_irq_bank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_irq_bank u_gpio_irq_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_valid_i (bus_valid),
        .bus_write_i (bus_write),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .pad_in_i    (pad_in),
        .pad_out_o   (pad_out),
        .pad_oe_o    (pad_oe),
        .irq_o       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
    endtask

    function automatic logic [31:0] next_status(
        input logic [31:0] st, input logic [31:0] old_p, input logic [31:0] new_p,
        input logic [31:0] sel, input logic [31:0] edg, input logic [31:0] pol,
        input logic [31:0] both, input logic [31:0] en);
        logic [31:0] ol, nl, hit;
        ol  = old_p & en;
        nl  = new_p & en;
        hit = ((nl & ~ol) & (~pol | both)) | ((~nl & ol) & (pol | both));
        return sel & en & ((edg & (st | hit)) | (~edg & (nl ^ pol)));
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        rd(8'h00, d); chk("R1 select", d, 32'h0);
        rd(8'h18, d); chk("R1 mask", d, 32'h0);
        rd(8'h10, d); chk("R1 status", d, 32'h0);
        rd(8'h50, d); chk("R1 inen", d, 32'h0);
        chk("R1 oe", pad_oe, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);

        // R2 / R12: direction, output data, select
        wr(8'h04, 32'h0000_00F0);
        wr(8'h08, 32'h0000_A5A5);
        chk("R2 oe", pad_oe, 32'h0000_00F0);
        chk("R2 out", pad_out, 32'h0000_A5A5);
        wr(8'h00, 32'h0000_0030);
        chk("R2 oe irq-sel", pad_oe, 32'h0000_00C0);
        rd(8'h04, d); chk("R12 dir readback", d, 32'h0000_00F0);
        rd(8'h14, d); chk("R12 clear reads 0", d, 32'h0);
        rd(8'h1C, d); chk("R12 unmask reads 0", d, 32'h0);
        rd(8'h40, d); chk("R12 unmapped reads 0", d, 32'h0);
        wr(8'h00, 32'h0);
        wr(8'h04, 32'h0000_0F00);

        // R3: two-edge latency, outputs still read the pad
        wr(8'h50, 32'hFFFF_FFFF);
        settle();
        @(negedge clk) pad_in = 32'h0000_0A00;
        @(posedge clk);
        #1 bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 8'h0C;
        #1 chk("R3 one edge old", bus_rdata, 32'h0);
        bus_valid = 1'b0;
        @(posedge clk);
        #1 bus_valid = 1'b1; bus_addr = 8'h0C;
        #1 chk("R3 two edges new", bus_rdata, 32'h0000_0A00);
        bus_valid = 1'b0;

        // R10: input enable gates level and status
        wr(8'h50, 32'hFFFF_F0FF);
        rd(8'h0C, d); chk("R10 gated level", d, 32'h0);
        wr(8'h00, 32'h0000_0F00);
        wr(8'h24, 32'h0000_0F00);
        wr(8'h4C, 32'h0000_0F00);
        @(negedge clk) pad_in = 32'h0000_0500;
        settle();
        rd(8'h10, d); chk("R10 no status", d, 32'h0);
        wr(8'h00, 32'h0); wr(8'h24, 32'h0); wr(8'h4C, 32'h0);
        wr(8'h50, 32'hFFFF_FFFF);
        @(negedge clk) pad_in = 32'h0;
        settle();

        // R4 R5 R6: lines 0 rising, 1 falling, 2 both, 3 level active-low
        wr(8'h24, 32'h0000_0007);
        wr(8'h20, 32'h0000_000A);
        wr(8'h4C, 32'h0000_0004);
        wr(8'h00, 32'h0000_001F);
        settle();
        rd(8'h10, d); chk("R6 active-low level", d, 32'h0000_0008);
        wr(8'h14, 32'h0000_000F);
        rd(8'h10, d); chk("R6 clear ignored", d, 32'h0000_0008);
        @(negedge clk) pad_in = 32'h0000_000F;
        settle();
        rd(8'h10, d); chk("R4 R5 rising", d, 32'h0000_0005);
        wr(8'h14, 32'h0000_0000);
        rd(8'h10, d); chk("R7 zero clear", d, 32'h0000_0005);
        wr(8'h14, 32'h0000_0005);
        rd(8'h10, d); chk("R7 clear", d, 32'h0);
        @(negedge clk) pad_in = 32'h0000_0000;
        settle();
        rd(8'h10, d); chk("R4 R5 R6 falling", d, 32'h0000_000E);

        // R8 R9: mask asymmetry and irq
        chk("R9 masked irq", {31'h0, irq}, 32'h0);
        wr(8'h1C, 32'h0000_0008);
        rd(8'h18, d); chk("R8 unmask", d, 32'h0000_0008);
        chk("R9 irq on", {31'h0, irq}, 32'h1);
        wr(8'h18, 32'hFFFF_FFF7);
        chk("R9 irq off", {31'h0, irq}, 32'h0);
        wr(8'h1C, 32'h0000_0003);
        wr(8'h18, 32'hFFFF_FFFE);
        rd(8'h18, d); chk("R8 write-0 masks", d, 32'h0000_0002);
        chk("R9 irq line1", {31'h0, irq}, 32'h1);
        wr(8'h14, 32'h0000_0006);
        chk("R9 irq cleared", {31'h0, irq}, 32'h0);

        // R11: line 4 edge mode but not an interrupt pin
        wr(8'h00, 32'h0000_000F);
        wr(8'h24, 32'h0000_0017);
        @(negedge clk) pad_in = 32'h0000_0010;
        settle();
        @(negedge clk) pad_in = 32'h0000_0000;
        settle();
        rd(8'h10, d); chk("R11 non-irq pin", d & 32'h10, 32'h0);

        // R7: clear collides with a new rising edge on line 0
        @(negedge clk) pad_in = 32'h0000_0001;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h1;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        rd(8'h10, d); chk("R7 edge beats clear", d & 32'h1, 32'h1);
        wr(8'h14, 32'h1);
        rd(8'h10, d); chk("R7 later clear", d & 32'h1, 32'h0);

        // random phase: R4 R5 R6 R7 R9 R10 R3
        for (int round = 0; round < 6; round++) begin
            logic [31:0] sel, edg, pol, both, en, msk, st, cur;
            sel = $urandom; edg = $urandom; pol = $urandom;
            both = $urandom; en = $urandom | 32'h00FF_00FF; msk = $urandom;
            cur = pad_in;
            wr(8'h00, sel); wr(8'h24, edg); wr(8'h20, pol);
            wr(8'h4C, both); wr(8'h50, en);
            wr(8'h1C, 32'hFFFF_FFFF); wr(8'h18, msk);
            settle();
            wr(8'h14, 32'hFFFF_FFFF);
            st = sel & en & ~edg & ((cur & en) ^ pol);
            rd(8'h18, d); chk("R8 random mask", d, msk);
            for (int step = 0; step < 10; step++) begin
                logic [31:0] nxt, c;
                nxt = $urandom;
                @(negedge clk) pad_in = nxt;
                settle();
                st = next_status(st, cur, nxt, sel, edg, pol, both, en);
                cur = nxt;
                rd(8'h10, d); chk("R4 R5 R6 random status", d, st);
                rd(8'h0C, d); chk("R3 R10 random level", d, cur & en);
                chk("R9 random irq", {31'h0, irq}, {31'h0, |(st & msk)});
                c = $urandom;
                wr(8'h14, c);
                st = st & ~(c & edg);
                rd(8'h10, d); chk("R7 random clear", d, st);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule